// File: doc/BRIEF.md
# Byte-Lane Pipelined Memory Datapath

This block is the storage and data side of a synchronous burst memory. A sequencer gives it an array address and a one-cycle access qualifier. The block decodes a whole-word write enable, a byte-write gate and four per-lane enables into lane write strobes. It then writes the selected 9-bit lanes of a 36-bit word into an internal array. Each lane holds 8 data bits and 1 parity bit. Lane 0 is bits 8:0, lane 1 is bits 17:9, lane 2 is bits 26:18 and lane 3 is bits 35:27. The top bit of each lane is its parity bit.

Read data travels through two registers before it reaches the output port. A drive-enable output tells the pad ring when to turn on its tri-state drivers. That output follows an asynchronous active-low output-enable pin, and a write on the previous edge forces it off. A sleep pin puts the block into a retention state. Entering that state takes two cycles, and so does leaving it. While the block is not ready, new accesses are ignored and the ready flag is low.

Top module: `byte_lane_mem_dp`

## Requirements
- R1: An accepted access with `gw_ni` low writes all four lanes of `wdata_i` to `addr_i`, whatever `bw_ni` and `lane_we_ni` are.
- R2: An accepted access with `gw_ni` high and `bw_ni` low writes each lane i whose `lane_we_ni[i]` is low (bits 9i+8:9i, parity included). The other lanes of that word keep their contents.
- R3: An accepted access with `gw_ni` and `bw_ni` both high is a read and changes no stored data.
- R4: Take a read accepted at rising edge e. After edge e+1, `rdata_o` holds the addressed word, and `drive_o` is high for that cycle provided `oe_ni` is low and no write was accepted at e+1.
- R5: In the cycle after an edge that accepts a write, `drive_o` is low, whatever `oe_ni` is.
- R6: `oe_ni` high forces `drive_o` low at once, without waiting for a clock edge.
- R7: An edge that samples `sleep_i` high while ready drops `ready_o` right after that edge. The block reaches retention two edges later, even if the pulse was shorter. While `ready_o` is low, accesses are ignored, stored data is kept and `drive_o` is low.
- R8: After retention, `ready_o` returns high on the second rising edge after the first edge that samples `sleep_i` low.
- R9: Reset clears `rdata_o` and `drive_o` and sets `ready_o` high. It leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access qualifier from the sequencer |
| addr_i | input | 4 | Array word address |
| gw_ni | input | 1 | Whole-word write enable, active low |
| bw_ni | input | 1 | Byte-write gate, active low |
| lane_we_ni | input | 4 | Per-lane write enables, active low |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Retention request |
| rdata_o | output | 36 | Pipelined read data |
| drive_o | output | 1 | Tri-state driver enable for the data pins |
| ready_o | output | 1 | High when accesses are accepted |

## Verification
The bench aims at these corner cases:
- A whole-word write issued with random byte controls. A decoder that lets the byte controls win would leave lanes stale on readback.
- Byte writes with every lane mask. A strobe swap or a parity bit left out of a lane shows up as wrong bits in one lane.
- A read directly followed by a write. Here the pipelined read data must be suppressed. A design that keys the drivers only on `oe_ni` would keep driving.
- Sleep pulses of one cycle, writes attempted during retention and wake-up, and resets in the middle of traffic. A wrong wake-up count, a write leaking into the array, or a reset that wipes the array all show up as a mismatch in ready timing or in the data read back.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic [1:0] {
    PWR_ON    = 2'd0,
    PWR_ENTER = 2'd1,
    PWR_OFF   = 2'd2,
    PWR_WAKE  = 2'd3
  } pwr_e;
endpackage

// File: rtl/bl_wr_decode.sv
module bl_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             start_i,
  input  logic             ready_i,
  input  logic             gw_ni,
  input  logic             bw_ni,
  input  logic [LANES-1:0] lane_we_ni,
  output logic [LANES-1:0] strb_o,
  output logic             rd_o
);
  logic acc;
  assign acc = start_i & ready_i;

  always_comb begin
    strb_o = '0;
    if (acc) begin
      if (!gw_ni)      strb_o = '1;
      else if (!bw_ni) strb_o = ~lane_we_ni;
    end
  end

  assign rd_o = acc & gw_ni & bw_ni;
endmodule

// File: rtl/bl_array.sv
module bl_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int WW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] strb_i,
  input  logic [WW-1:0]    wdata_i,
  output logic [WW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (strb_i[g]) mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/bl_rd_pipe.sv
module bl_rd_pipe #(
  parameter int WW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          awake_i,
  input  logic          oe_ni,
  input  logic [WW-1:0] arr_i,
  output logic [WW-1:0] rdata_o,
  output logic          drive_o
);
  logic [WW-1:0] s1_q, s2_q;
  logic          s1_vld_q, s2_vld_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q     <= '0;
      s2_q     <= '0;
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      if (rd_i) s1_q <= arr_i;
      s1_vld_q <= rd_i;
      s2_q     <= s1_q;
      s2_vld_q <= s1_vld_q;
      wr_q     <= wr_i;
    end
  end

  assign rdata_o = s2_q;
  // write on the last edge overrides oe
  assign drive_o = s2_vld_q & ~wr_q & awake_i & ~oe_ni;

  AST_RD_STAGE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> s1_vld_q); // R4
  AST_RD_STAGE2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_q |=> (s2_vld_q && rdata_o == $past(s1_q))); // R4
  AST_OE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o); // R6
endmodule

// File: rtl/bl_power.sv
module bl_power #(
  parameter int SLEEP_CYC = 2,
  localparam int CW = $clog2(SLEEP_CYC) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic ready_o
);
  import bl_pkg::*;
  localparam logic [CW-1:0] LAST = CW'(SLEEP_CYC - 1);

  pwr_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PWR_ON;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        PWR_ON: if (sleep_i) begin
          st_q  <= PWR_ENTER;
          cnt_q <= '0;
        end
        PWR_ENTER: begin
          if (cnt_q == LAST) st_q <= PWR_OFF;
          else               cnt_q <= cnt_q + 1'b1;
        end
        PWR_OFF: if (!sleep_i) begin
          st_q  <= PWR_WAKE;
          cnt_q <= '0;
        end
        PWR_WAKE: begin
          if (sleep_i)            st_q <= PWR_OFF;
          else if (cnt_q == LAST) st_q <= PWR_ON;
          else                    cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= PWR_ON;
      endcase
    end
  end

  assign ready_o = (st_q == PWR_ON);

  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(sleep_i)); // R7
  AST_WAKE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (!$past(sleep_i) && !$past(sleep_i, 2))); // R8
endmodule

// File: rtl/byte_lane_mem_dp.sv
module byte_lane_mem_dp #(
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int DEPTH     = 16,
  parameter int SLEEP_CYC = 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int WW       = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             gw_ni,
  input  logic             bw_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic [WW-1:0]    wdata_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  output logic [WW-1:0]    rdata_o,
  output logic             drive_o,
  output logic             ready_o
);
  logic [LANES-1:0] lane_strb;
  logic             rd_req;
  logic [WW-1:0]    arr_rd;

  bl_power #(.SLEEP_CYC(SLEEP_CYC)) i_power (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sleep_i(sleep_i),
    .ready_o(ready_o)
  );

  bl_wr_decode #(.LANES(LANES)) i_decode (
    .start_i   (start_i),
    .ready_i   (ready_o),
    .gw_ni     (gw_ni),
    .bw_ni     (bw_ni),
    .lane_we_ni(lane_we_ni),
    .strb_o    (lane_strb),
    .rd_o      (rd_req)
  );

  bl_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) i_array (
    .clk_i  (clk_i),
    .addr_i (addr_i),
    .strb_i (lane_strb),
    .wdata_i(wdata_i),
    .rdata_o(arr_rd)
  );

  bl_rd_pipe #(.WW(WW)) i_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_req),
    .wr_i   (|lane_strb),
    .awake_i(ready_o),
    .oe_ni  (oe_ni),
    .arr_i  (arr_rd),
    .rdata_o(rdata_o),
    .drive_o(drive_o)
  );

  AST_GW_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && !gw_ni) |-> (&lane_strb)); // R1
  AST_BYTE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && gw_ni && !bw_ni) |-> (lane_strb == ~lane_we_ni)); // R2
  AST_READ_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |-> (lane_strb == '0)); // R3
  AST_WRITE_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_strb) |=> !drive_o); // R5
  AST_IDLE_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (lane_strb == '0 && !rd_req && !drive_o)); // R7
endmodule

// File: tb/test_byte_lane_mem_dp.sv
module test_byte_lane_mem_dp;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        gw_ni = 1'b1;
  logic        bw_ni = 1'b1;
  logic [3:0]  lane_we_ni = 4'hF;
  logic [35:0] wdata_i = '0;
  logic        oe_ni = 1'b0;
  logic        sleep_i = 1'b0;
  logic [35:0] rdata_o;
  logic        drive_o;
  logic        ready_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model
  logic [35:0] m_mem [16];
  logic [35:0] m_s1 = '0, m_q = '0;
  bit m_s1v = 0, m_qv = 0, m_wr = 0;
  int m_pst = 0, m_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  byte_lane_mem_dp i_byte_lane_mem_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .gw_ni(gw_ni), .bw_ni(bw_ni), .lane_we_ni(lane_we_ni), .wdata_i(wdata_i),
    .oe_ni(oe_ni), .sleep_i(sleep_i), .rdata_o(rdata_o), .drive_o(drive_o),
    .ready_o(ready_o)
  );

  function automatic logic [3:0] exp_strb(logic gw, logic bw, logic [3:0] we);
    if (!gw) return 4'hF;
    if (!bw) return ~we;
    return 4'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit acc;
    logic [3:0] s;
    acc = start_i && (m_pst == 0);
    s = acc ? exp_strb(gw_ni, bw_ni, lane_we_ni) : 4'h0;
    m_qv = m_s1v; m_q = m_s1;
    m_s1v = acc && gw_ni && bw_ni;
    if (m_s1v) m_s1 = m_mem[addr_i];
    for (int i = 0; i < 4; i++)
      if (s[i]) m_mem[addr_i][i*9 +: 9] = wdata_i[i*9 +: 9];
    m_wr = |s;
    case (m_pst)
      0: if (sleep_i) begin m_pst = 1; m_cnt = 0; end
      1: if (m_cnt == 1) m_pst = 2; else m_cnt++;
      2: if (!sleep_i) begin m_pst = 3; m_cnt = 0; end
      default: if (sleep_i) m_pst = 2; else if (m_cnt == 1) m_pst = 0; else m_cnt++;
    endcase
  endtask

  // one clock: model, edge, then checks at the falling edge
  task automatic step();
    bit exp_drv;
    model_edge();
    @(posedge clk_i);
    @(negedge clk_i);
    exp_drv = m_qv && !m_wr && !oe_ni && (m_pst == 0);
    chk(ready_o == (m_pst == 0), "R7_R8 ready", 36'(ready_o), 36'(m_pst == 0));
    chk(drive_o == exp_drv, "R4_R5 drive", 36'(drive_o), 36'(exp_drv));
    if (exp_drv) chk(rdata_o == m_q, "R4 rdata", rdata_o, m_q);
  endtask

  task automatic set_op(bit st, logic [3:0] a, bit gw, bit bw, logic [3:0] we, logic [35:0] d);
    start_i = st; addr_i = a; gw_ni = gw; bw_ni = bw; lane_we_ni = we; wdata_i = d;
  endtask

  task automatic idle();
    set_op(0, '0, 1, 1, 4'hF, '0);
  endtask

  task automatic read_expect(logic [3:0] a, logic [35:0] exp, string req);
    set_op(1, a, 1, 1, 4'hF, '0); step();
    idle(); step();
    chk(drive_o && rdata_o == exp, req, rdata_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(rdata_o == '0 && !drive_o, "R9 reset outputs", rdata_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R9 ready after reset", 36'(ready_o), 36'd1);

    // R1: whole-word writes with random byte controls
    for (int a = 0; a < 16; a++) begin
      set_op(1, 4'(a), 0, 1'($urandom), 4'($urandom), {$urandom, 4'($urandom)});
      step();
    end
    idle(); step();
    read_expect(4'd2, m_mem[2], "R1 full write readback");

    // R2: byte write lanes 0 and 2
    set_op(1, 4'd4, 0, 1, 4'hF, 36'h0_0000_0000); step();
    set_op(1, 4'd4, 1, 0, 4'b1010, 36'hF_FFFF_FFFF); step();
    idle(); step();
    read_expect(4'd4, 36'h0_07FC_01FF, "R2 lane mask 0101");

    // R3: read leaves data alone
    read_expect(4'd4, 36'h0_07FC_01FF, "R3 repeat read");

    // R6: async oe
    set_op(1, 4'd4, 1, 1, 4'hF, '0); step();
    idle(); step();
    oe_ni = 1'b1; #1;
    chk(!drive_o, "R6 oe async off", 36'(drive_o), 36'd0);
    oe_ni = 1'b0; #1;
    chk(drive_o, "R6 oe async on", 36'(drive_o), 36'd1);

    // R5: read followed by write mutes the read data
    set_op(1, 4'd5, 1, 1, 4'hF, '0); step();
    set_op(1, 4'd6, 0, 1, 4'hF, 36'h1_2345_6789); step();
    chk(!drive_o, "R5 write mutes", 36'(drive_o), 36'd0);
    idle(); step();

    // R7: sleep, writes ignored
    sleep_i = 1'b1; step();
    chk(!ready_o, "R7 ready low", 36'(ready_o), 36'd0);
    set_op(1, 4'd6, 0, 1, 4'hF, 36'hA_AAAA_AAAA);
    repeat (4) step();
    idle();
    // R8: wake count
    sleep_i = 1'b0; step();
    chk(!ready_o, "R8 wake edge1", 36'(ready_o), 36'd0);
    step();
    chk(!ready_o, "R8 wake edge2", 36'(ready_o), 36'd0);
    step();
    chk(ready_o, "R8 wake edge3", 36'(ready_o), 36'd1);
    read_expect(4'd6, 36'h1_2345_6789, "R7 retained");

    // R7: one-cycle pulse still completes full sleep
    sleep_i = 1'b1; step(); sleep_i = 1'b0;
    repeat (4) step();
    chk(!ready_o, "R7 pulse still asleep", 36'(ready_o), 36'd0);
    step();
    chk(ready_o, "R7 pulse wake", 36'(ready_o), 36'd1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 3)      set_op(1, 4'($urandom), 1, 1, 4'($urandom), '0);
      else if (op == 3) set_op(1, 4'($urandom), 0, 1'($urandom), 4'($urandom), {$urandom, 4'($urandom)});
      else if (op < 6) set_op(1, 4'($urandom), 1, 0, 4'($urandom), {$urandom, 4'($urandom)});
      else             idle();
      oe_ni = ($urandom % 6 == 0);
      if ($urandom % 64 == 0) sleep_i = ~sleep_i;
      step();
    end
    sleep_i = 1'b0; oe_ni = 1'b0; idle();
    repeat (6) step();

    // R9: reset mid-run keeps array
    rst_ni = 1'b0;
    m_s1 = '0; m_q = '0; m_s1v = 0; m_qv = 0; m_wr = 0; m_pst = 0; m_cnt = 0;
    #1;
    chk(rdata_o == '0 && !drive_o, "R9 reset clears pipe", rdata_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    read_expect(4'd6, m_mem[6], "R9 array retained");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule